// File: doc/BRIEF.md
# Banked Event Combiner

The block gathers a wide set of single-cycle event pulses into banks of sticky flag bits. Each bank has a mask that selects which of its flags take part in that bank's combined output. The block also offers a filtered read-back in which only the contributing flags appear. Software services a combined output with a loop. It reads the bank's filtered flags, writes that value to the bank's clear register, handles the events, and repeats until the filtered view reads zero. A pulse that lands in the same cycle as the clear of its own flag keeps the flag set, so the loop cannot lose an event.

Flags that are masked out may stay set indefinitely. They remain visible in the raw flag register but never raise the combined output. A flat register port with a combinational read path gives access to four register types per bank. Writes take effect at the next rising clock edge.

Top module: `evt_combiner`

## Requirements
- R1: After reset every flag is 0, every mask bit is 1 and every combined output is 0.
- R2: Event input bit `32*b+i` sets flag bit i of bank b at the rising edge where it is sampled 1. The flag stays set until it is cleared.
- R3: A write to a bank's clear register clears exactly the flag bits written as 1 and leaves the others unchanged.
- R4: If an event pulse and a clear of the same flag bit occur in the same cycle, the flag remains set afterwards.
- R5: The masked-flag register of a bank reads as the raw flags AND NOT mask. A mask bit of 1 excludes that event.
- R6: `comb_out[b]` is 1 exactly when bank b's masked-flag register is nonzero.
- R7: A flag whose mask bit is 1 stays readable in the raw flag register and does not raise the combined output.
- R8: The clear register reads as 0. Writes to the raw-flag and masked-flag registers have no effect.
- R9: The register address is {type, bank}. `reg_addr[3:2]` gives the type (0 raw flags, 1 mask, 2 masked flags, 3 clear) and `reg_addr[1:0]` gives the bank. A write to the mask register loads all 32 bits at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 128 | Event pulses, bank b on bits 32b..32b+31 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address {type, bank} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| comb_out | output | 4 | Combined event per bank |

## Verification
Two functions can fall in the same cycle: a pulse setting a flag and a clear-register write aimed at that same bit. The bench provokes this directly. It first sets a flag, then drives the same event bit again while writing a clear mask that covers that bit and others. The set bit is expected to survive while the other covered bits drop. The random phase also creates such overlaps by drawing event and clear patterns independently. Every outcome is judged against a bench model that applies the clear before the set.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [1:0] {
    RT_RAW   = 2'd0,
    RT_MASK  = 2'd1,
    RT_MFLAG = 2'd2,
    RT_CLEAR = 2'd3
  } reg_type_e;

  // Contribution of flags given a mask where 1 excludes.
  function automatic logic [31:0] contrib(input logic [31:0] flags, input logic [31:0] excl);
    return flags & ~excl;
  endfunction

  // Next flag state: clear first, then set, so a set in the same cycle wins.
  function automatic logic [31:0] next_flags(input logic [31:0] cur, input logic [31:0] clr,
                                             input logic [31:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         mask_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] mflag,
  output logic         comb
);
  logic [W-1:0] clr_vec;
  logic [W-1:0] flag_d;

  assign clr_vec = clr_we ? wdata : '0;
  assign flag_d  = next_flags(flag_q, clr_vec, evt);
  assign mflag   = contrib(flag_q, mask_q);
  assign comb    = |mflag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= wdata;
  end

  // R2 / R4: every sampled event bit is set afterwards, clear or not
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flag_q & $past(evt)) == $past(evt)));
  // R3: cleared bits without a concurrent event are 0 afterwards
  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((flag_q & $past(wdata) & ~$past(evt)) == '0));
  // R2: flags hold when nothing touches them
  a_r2_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && evt == '0) |=> $stable(flag_q));
  // R9: mask write loads the written value
  a_r9_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(wdata)));
endmodule

// File: rtl/evc_regif.sv
module evc_regif
  import evc_pkg::*;
#(
  parameter int NB = 4,
  parameter int W  = 32,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int AW = BW + 2
) (
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [W-1:0]         wdata,
  input  logic [NB-1:0][W-1:0] flags,
  input  logic [NB-1:0][W-1:0] masks,
  input  logic [NB-1:0][W-1:0] mflags,
  output logic [NB-1:0]        mask_we,
  output logic [NB-1:0]        clr_we,
  output logic [W-1:0]         rdata
);
  reg_type_e     sel_type;
  logic [BW-1:0] sel_bank;
  logic          unused_wdata;

  assign sel_type = reg_type_e'(addr[AW-1 -: 2]);
  assign sel_bank = addr[BW-1:0];
  assign unused_wdata = ^wdata;

  always_comb begin
    mask_we = '0;
    clr_we  = '0;
    if (we) begin
      if (sel_type == RT_MASK)  mask_we[sel_bank] = 1'b1;
      if (sel_type == RT_CLEAR) clr_we[sel_bank]  = 1'b1;
    end
  end

  always_comb begin
    unique case (sel_type)
      RT_RAW:   rdata = flags[sel_bank];
      RT_MASK:  rdata = masks[sel_bank];
      RT_MFLAG: rdata = mflags[sel_bank];
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_combiner.sv
module evt_combiner
  import evc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32,
  localparam int NEVT = NUM_BANKS * BANK_W,
  localparam int BW   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int AW   = BW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NEVT-1:0]  evt_in,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [BANK_W-1:0] reg_wdata,
  output logic [BANK_W-1:0] reg_rdata,
  output logic [NUM_BANKS-1:0] comb_out
);
  logic [NUM_BANKS-1:0][BANK_W-1:0] flags;
  logic [NUM_BANKS-1:0][BANK_W-1:0] masks;
  logic [NUM_BANKS-1:0][BANK_W-1:0] mflags;
  logic [NUM_BANKS-1:0]             mask_we;
  logic [NUM_BANKS-1:0]             clr_we;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    evc_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_in[b*BANK_W +: BANK_W]),
      .mask_we (mask_we[b]),
      .clr_we  (clr_we[b]),
      .wdata   (reg_wdata),
      .flag_q  (flags[b]),
      .mask_q  (masks[b]),
      .mflag   (mflags[b]),
      .comb    (comb_out[b])
    );
  end

  evc_regif #(.NB(NUM_BANKS), .W(BANK_W)) u_regif (
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .flags   (flags),
    .masks   (masks),
    .mflags  (mflags),
    .mask_we (mask_we),
    .clr_we  (clr_we),
    .rdata   (reg_rdata)
  );

  // R6: a zero masked-flag read-back means the bank's combined output is low
  a_r6_comb_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[AW-1 -: 2] == 2'd2 && reg_rdata == '0) |-> !comb_out[reg_addr[BW-1:0]]);
  // R8: clear register always reads 0
  a_r8_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[AW-1 -: 2] == 2'd3) |-> (reg_rdata == '0));
endmodule

// File: tb/evt_combiner_bench.sv
`timescale 1ns/1ps
module evt_combiner_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] evt_in = '0;
  logic         reg_we = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [3:0]   comb_out;

  int errors = 0;
  int checks = 0;
  logic [31:0] m_flag [4];
  logic [31:0] m_mask [4];

  always #10 clk = ~clk;

  evt_combiner u_evt_combiner (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .comb_out(comb_out)
  );

  function automatic logic [31:0] exp_visible(input logic [31:0] f, input logic [31:0] m);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (m[i] == 1'b0) ? f[i] : 1'b0;
    return r;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] t, input logic [1:0] b, output logic [31:0] v);
    reg_addr = {t, b};
    #1;
    v = reg_rdata;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    for (int b = 0; b < 4; b++) begin
      read_reg(2'd0, 2'(b), v);
      check("R2", {tag, " raw"}, v, m_flag[b]);
      read_reg(2'd1, 2'(b), v);
      check("R9", {tag, " mask"}, v, m_mask[b]);
      read_reg(2'd2, 2'(b), v);
      check("R5", {tag, " masked"}, v, exp_visible(m_flag[b], m_mask[b]));
      read_reg(2'd3, 2'(b), v);
      check("R8", {tag, " clear reads"}, v, 32'd0);
      check("R6", {tag, " comb"}, {31'd0, comb_out[b]},
            {31'd0, exp_visible(m_flag[b], m_mask[b]) != 32'd0});
    end
  endtask

  // One cycle of stimulus, model updated with clear applied before set.
  task automatic step(input logic [127:0] ev, input logic we, input logic [1:0] t,
                      input logic [1:0] b, input logic [31:0] d);
    @(negedge clk);
    evt_in = ev; reg_we = we; reg_addr = {t, b}; reg_wdata = d;
    @(negedge clk);
    evt_in = '0; reg_we = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] c;
      c = (we && t == 2'd3 && b == 2'(k)) ? d : 32'd0;
      m_flag[k] = (m_flag[k] & ~c) | ev[k*32 +: 32];
      if (we && t == 2'd1 && b == 2'(k)) m_mask[k] = d;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int b = 0; b < 4; b++) begin m_flag[b] = '0; m_mask[b] = '1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", "comb after reset", {28'd0, comb_out}, 32'd0);
    check_all("R1 reset");

    // R7: masked-out event stays in raw, no comb
    step(128'h1 << 40, 1'b0, 2'd0, 2'd0, 0);
    check_all("R7 masked event");
    // unmask bank 1 bit 8 -> comb rises
    step('0, 1'b1, 2'd1, 2'd1, 32'hFFFF_FEFF);
    check_all("R6 unmask");
    // R8: writes to raw and masked registers ignored
    step('0, 1'b1, 2'd0, 2'd1, 32'd0);
    step('0, 1'b1, 2'd2, 2'd1, 32'd0);
    check_all("R8 ro write");
    // R4: collision, same bit set and cleared in one cycle; other bit drops
    step('0, 1'b1, 2'd1, 2'd2, 32'h0);
    step((128'h1 << 64) | (128'h1 << 67), 1'b0, 2'd0, 2'd0, 0);
    step(128'h1 << 64, 1'b1, 2'd3, 2'd2, 32'h0000_0009);
    read_reg(2'd0, 2'd2, v);
    check("R4", "set wins over clear", v, 32'h0000_0001);
    // R3: read-and-clear loop ends at zero
    read_reg(2'd2, 2'd2, v);
    step('0, 1'b1, 2'd3, 2'd2, v);
    read_reg(2'd2, 2'd2, v);
    check("R3", "loop ends at zero", v, 32'd0);
    check("R6", "comb low after loop", {31'd0, comb_out[2]}, 32'd0);
    check_all("R3 directed");

    // random phase
    for (int n = 0; n < 400; n++) begin
      logic [127:0] ev;
      for (int k = 0; k < 4; k++) ev[k*32 +: 32] = $urandom & $urandom & $urandom;
      step(ev, ($urandom % 3) != 0, 2'($urandom), 2'($urandom), $urandom & $urandom);
      check_all("R2 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule